// File: doc/BRIEF.md
# Absolute-Address Memory Access Expander

This block turns a single load or store that names a full 32-bit address into two real instruction words. A 16-bit immediate offset cannot carry a whole address, so the block splits it into two parts. The first word is a load-upper-immediate that places a corrected upper half into register 1, the scratch register that is kept back for this kind of expansion. The second word is the requested memory access, with register 1 as its base and the low 16 bits of the address as its offset.

The memory instruction sign-extends its offset before adding it to the base. When address bit 15 is set, that offset reads as negative, so the block adds bit 15 to the upper half. The rebuilt address then matches the request exactly. The addition wraps modulo 2^16.

Requests arrive on a valid/ready port, and the block accepts one only while it is idle. The two words leave on a valid/ready stream. The block sits where a decode stage or a hardware assembler would feed a pipeline.

Top module: `abs_mem_expander`

## Requirements
- R1: The first word of an expansion is {6'b001111, 5'd0, 5'd1, U}. It is a load-upper-immediate with source field 0, destination register 1, and immediate U.
- R2: The second word is {OP, 5'd1, RT, A[15:0]}. OP is the requested opcode, the base is register 1, RT is the requested target register, and A is the requested address.
- R3: U equals (A >> 16) + A[15], modulo 2^16. It follows that (U << 16) + sign-extend(A[15:0]) equals A, for example A = 0x10010000 gives U = 0x1001 with offset 0x0000, and A = 0xFFFF8000 gives U = 0x0000 with offset 0x8000.
- R4: The upper-immediate word is always issued before the memory word. `out_last` is 0 on the first word and 1 on the second.
- R5: `req_ready` is 1 only while idle. A request held valid while an expansion is in progress has no effect on the words emitted.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` and `out_last` hold their values.
- R7: The accepted opcodes are 6'b100011 (load word) and 6'b101011 (store word). Any other opcode sets `err_bad_op` for exactly the one cycle after acceptance, and nothing is emitted. The block stays idle.
- R8: When RT is 1, `warn_rt_conflict` is 1 while both words of that expansion are presented. Both words are still emitted. For any other RT it is 0.
- R9: After reset, `out_valid` and `err_bad_op` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 6 | Memory opcode (load word or store word) |
| req_rt | input | 5 | Target register of the memory access |
| req_addr | input | 32 | Full absolute address |
| out_valid | output | 1 | Instruction word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Emitted instruction word |
| out_last | output | 1 | Word is the second (memory) word |
| err_bad_op | output | 1 | One-cycle pulse: opcode refused |
| warn_rt_conflict | output | 1 | Target register collides with scratch register |

## Verification
A request accepted on one rising edge presents the upper-immediate word in the very next cycle. Each output handshake edge brings the next word, or a return to idle, one cycle later. A refused opcode shows its error pulse in the cycle right after the accepting edge.

The bench drives its inputs after the falling edge and reads every result at the following falling edge. The words are therefore compared in the cycle each one is due. Random output stalls check that a held word does not move. The upper half is predicted with a rounding formula, (A + 0x8000) >> 16, which differs from the design's own formula. The received pair is also rebuilt into an address and compared with the request.

// File: rtl/expander_pkg.sv
package expander_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int REG_W  = 5;
  localparam int OP_W   = 6;

  localparam logic [OP_W-1:0]  OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0]  OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0]  OP_UPPER = 6'b001111;
  localparam logic [REG_W-1:0] SCRATCH  = 5'd1;
  localparam logic [REG_W-1:0] ZERO_REG = 5'd0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2
  } exp_state_e;

  // corrected upper half: adds the sign bit of the low half, wraps mod 2^16
  function automatic logic [HALF_W-1:0] upper_of(input logic [WORD_W-1:0] a);
    return a[WORD_W-1:HALF_W] + {{(HALF_W-1){1'b0}}, a[HALF_W-1]};
  endfunction

  function automatic logic [HALF_W-1:0] lower_of(input logic [WORD_W-1:0] a);
    return a[HALF_W-1:0];
  endfunction

  function automatic logic op_ok(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

  function automatic logic [WORD_W-1:0] mk_upper(input logic [HALF_W-1:0] u);
    return {OP_UPPER, ZERO_REG, SCRATCH, u};
  endfunction

  function automatic logic [WORD_W-1:0] mk_mem(input logic [OP_W-1:0] op,
                                               input logic [REG_W-1:0] rt,
                                               input logic [HALF_W-1:0] lo);
    return {op, SCRATCH, rt, lo};
  endfunction

  function automatic logic [WORD_W-1:0] rebuild(input logic [HALF_W-1:0] u,
                                                input logic [HALF_W-1:0] lo);
    return {u, {HALF_W{1'b0}}} + {{HALF_W{lo[HALF_W-1]}}, lo};
  endfunction
endpackage

// File: rtl/expander_split.sv
module expander_split
  import expander_pkg::*;
(
  input  logic [WORD_W-1:0] addr,
  output logic [HALF_W-1:0] upper,
  output logic [HALF_W-1:0] lower
);
  assign upper = upper_of(addr);
  assign lower = lower_of(addr);

  // R3: the pair rebuilds the exact address after sign extension
  always_comb begin
    if (!$isunknown(addr)) begin
      p_rebuild_r3: assert (rebuild(upper, lower) == addr)
        else $error("split does not rebuild address");
    end
  end
endmodule

// File: rtl/expander_ctrl.sv
module expander_ctrl
  import expander_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_good,
  input  logic out_ready,
  output logic req_ready,
  output logic load_en,
  output logic out_valid,
  output logic out_last,
  output logic err_pulse
);
  exp_state_e state_q, state_d;

  logic acc_ev, acc_good_ev, acc_bad_ev, hs_ev;

  assign req_ready   = (state_q == ST_IDLE);
  assign acc_ev      = req_valid && req_ready;
  assign acc_good_ev = acc_ev && req_good;
  assign acc_bad_ev  = acc_ev && !req_good;
  assign out_valid   = (state_q == ST_HI) || (state_q == ST_LO);
  assign out_last    = (state_q == ST_LO);
  assign hs_ev       = out_valid && out_ready;
  assign load_en     = acc_good_ev;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (acc_good_ev) state_d = ST_HI;
      ST_HI:   if (hs_ev)       state_d = ST_LO;
      ST_LO:   if (hs_ev)       state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      err_pulse <= 1'b0;
    end else begin
      state_q   <= state_d;
      err_pulse <= acc_bad_ev;
    end
  end

  // R6: a stalled word stays presented
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_last));
  // R4: upper word handshake is followed by the memory word
  p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ev && !out_last |=> out_valid && out_last);
  // R5: no acceptance while a word is presented
  p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
  // R7: refused opcode pulses error and emits nothing
  p_badop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad_ev |=> err_pulse && !out_valid && req_ready);
endmodule

// File: rtl/expander_emit.sv
module expander_emit
  import expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [OP_W-1:0]   op_in,
  input  logic [REG_W-1:0]  rt_in,
  input  logic [HALF_W-1:0] upper_in,
  input  logic [HALF_W-1:0] lower_in,
  input  logic              sel_mem,
  input  logic              active,
  input  logic              out_ready,
  output logic [WORD_W-1:0] word,
  output logic              conflict
);
  logic [OP_W-1:0]   op_q;
  logic [REG_W-1:0]  rt_q;
  logic [HALF_W-1:0] upper_q, lower_q;
  logic [WORD_W-1:0] hi_word, lo_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_LOAD;
      rt_q    <= '0;
      upper_q <= '0;
      lower_q <= '0;
    end else if (load_en) begin
      op_q    <= op_in;
      rt_q    <= rt_in;
      upper_q <= upper_in;
      lower_q <= lower_in;
    end
  end

  assign hi_word  = mk_upper(upper_q);
  assign lo_word  = mk_mem(op_q, rt_q, lower_q);
  assign word     = sel_mem ? lo_word : hi_word;
  assign conflict = active && (rt_q == SCRATCH);

  // R6: stalled word does not change
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active && !out_ready |=> $stable(word));
  // R2: memory word always uses the scratch register as base
  p_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active && sel_mem |-> word[25:21] == SCRATCH);
endmodule

// File: rtl/abs_mem_expander.sv
module abs_mem_expander
  import expander_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_op,
  input  logic [4:0]  req_rt,
  input  logic [31:0] req_addr,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word,
  output logic        out_last,
  output logic        err_bad_op,
  output logic        warn_rt_conflict
);
  logic [HALF_W-1:0] split_upper, split_lower;
  logic              req_good, load_en;

  assign req_good = op_ok(req_op);

  expander_split u_split (
    .addr  (req_addr),
    .upper (split_upper),
    .lower (split_lower)
  );

  expander_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_good  (req_good),
    .out_ready (out_ready),
    .req_ready (req_ready),
    .load_en   (load_en),
    .out_valid (out_valid),
    .out_last  (out_last),
    .err_pulse (err_bad_op)
  );

  expander_emit u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .op_in     (req_op),
    .rt_in     (req_rt),
    .upper_in  (split_upper),
    .lower_in  (split_lower),
    .sel_mem   (out_last),
    .active    (out_valid),
    .out_ready (out_ready),
    .word      (out_word),
    .conflict  (warn_rt_conflict)
  );

  // R1: the first word is always an upper-immediate into the scratch register
  p_upper_fmt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> out_word[31:16] == {OP_UPPER, ZERO_REG, SCRATCH});
  // R8: conflict is only reported while words are presented
  p_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    warn_rt_conflict |-> out_valid);
endmodule

// File: tb/tb_abs_mem_expander.sv
module tb_abs_mem_expander;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = 6'b100011;
  logic [4:0]  req_rt = 5'd0;
  logic [31:0] req_addr = 32'd0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_word;
  logic        out_last;
  logic        err_bad_op;
  logic        warn_rt_conflict;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  abs_mem_expander dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rt(req_rt), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .err_bad_op(err_bad_op),
    .warn_rt_conflict(warn_rt_conflict)
  );

  function automatic logic [15:0] exp_upper(input logic [31:0] a);
    logic [31:0] r;
    r = a + 32'h0000_8000;
    return r[31:16];
  endfunction

  function automatic logic [31:0] exp_word(input int idx, input logic [5:0] op,
                                           input logic [4:0] rt, input logic [31:0] a);
    if (idx == 0) return {16'h3C01, exp_upper(a)};
    return {op, 5'd1, rt, a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic expand(input logic [5:0] op, input logic [4:0] rt,
                        input logic [31:0] a);
    logic [31:0] got [2];
    logic [31:0] prev;
    int idx, stall;
    bit held;
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 idle ready", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op; req_rt = rt; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    // keep a bogus request valid while busy: it must have no effect (R5)
    req_addr = ~a; req_rt = ~rt;
    idx = 0; stall = 0; held = 0; prev = '0;
    while (idx < 2) begin
      chk(out_valid == 1'b1, "R4 word present", {31'd0, out_valid}, 32'd1);
      chk(req_ready == 1'b0, "R5 busy", {31'd0, req_ready}, 32'd0);
      chk(out_last == (idx == 1), "R4 last flag", {31'd0, out_last}, idx);
      chk(warn_rt_conflict == (rt == 5'd1), "R8 conflict",
          {31'd0, warn_rt_conflict}, {31'd0, rt == 5'd1});
      if (held)
        chk(out_word == prev, "R6 stall hold", out_word, prev);
      if (idx == 0)
        chk(out_word == exp_word(0, op, rt, a), "R1 upper word", out_word,
            exp_word(0, op, rt, a));
      else
        chk(out_word == exp_word(1, op, rt, a), "R2 memory word", out_word,
            exp_word(1, op, rt, a));
      got[idx] = out_word;
      prev = out_word;
      out_ready = ($urandom_range(0, 2) != 0) || (stall >= 3);
      if (out_ready && idx == 1) req_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (out_ready) begin
        idx++; stall = 0; held = 0;
      end else begin
        stall++; held = 1;
      end
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R5 back to idle",
        {30'd0, out_valid, req_ready}, 32'd1);
    chk({got[0][15:0], 16'h0} + {{16{got[1][15]}}, got[1][15:0]} == a,
        "R3 rebuild", {got[0][15:0], 16'h0} + {{16{got[1][15]}}, got[1][15:0]}, a);
  endtask

  task automatic bad_op(input logic [5:0] op, input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_rt = 5'd7; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(err_bad_op == 1'b1, "R7 error pulse", {31'd0, err_bad_op}, 32'd1);
    chk(out_valid == 1'b0, "R7 nothing emitted", {31'd0, out_valid}, 32'd0);
    chk(req_ready == 1'b1, "R7 stays idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk(err_bad_op == 1'b0, "R7 one cycle", {31'd0, err_bad_op}, 32'd0);
    chk(out_valid == 1'b0, "R7 still nothing", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    logic [31:0] a;
    logic [5:0]  op;
    void'($urandom(32'h5EED_1234));
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9 reset valid", {31'd0, out_valid}, 32'd0);
    chk(req_ready == 1'b1, "R9 reset ready", {31'd0, req_ready}, 32'd1);
    chk(err_bad_op == 1'b0, "R9 reset error", {31'd0, err_bad_op}, 32'd0);
    rst_n = 1'b1;

    // directed corners (R3)
    expand(6'b100011, 5'd2, 32'h1001_0000);
    expand(6'b101011, 5'd9, 32'hFFFF_8000);
    expand(6'b100011, 5'd31, 32'h0000_8000);
    expand(6'b100011, 5'd4, 32'h1234_FFFF);
    expand(6'b101011, 5'd0, 32'h0000_7FFF);
    expand(6'b100011, 5'd1, 32'hABCD_9876);   // R8 scratch collision
    expand(6'b101011, 5'd1, 32'h0000_0000);
    bad_op(6'b001111, 32'h1001_0004);
    bad_op(6'b000000, 32'hDEAD_BEEF);
    bad_op(6'b101010, 32'h0000_8000);

    for (int i = 0; i < 60; i++) begin
      a = $urandom();
      if (i % 2 == 0) a[15] = 1'b1;
      op = ($urandom_range(0, 1) == 0) ? 6'b100011 : 6'b101011;
      if (i % 10 == 9) bad_op(6'($urandom_range(0, 63)) & 6'b011111, a);
      else expand(op, 5'($urandom_range(0, 31)), a);
    end
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end
endmodule